// File: doc/BRIEF.md
# Watchdog Service Request Synchronizer

This block holds a two-bit service register on the bus clock, one request bit for each of two watchdog subcounters, and carries each request into a slow low-frequency clock domain. In the slow domain the request clears the chosen subcounter to zero. The request bit then returns to zero on the bus side once the clear has been acknowledged. Software sets a bit by writing a one. A nonzero lock field throws the write away. Software polls the bit until it reads zero before it asks for the same subcounter again.

A small model of the two subcounters sits in the slow domain so that the effect of a service can be observed. Each subcounter has an enable, a lower limit and a preload path. A service to a disabled subcounter is ignored: the count is kept, a preloaded value included, and no lower-limit flag is raised. The request bit still clears. Each crossing uses a toggle handshake with two-flop synchronizers in both directions.

Top module: `wdt_svc_sync`

## Requirements
- R1: After reset, `rd_data` is 0, both counts are 0 and `lower_act` is 0.
- R2: A write of 1 to bit 0 or bit 1 of `wr_data` with `wr_en` high and `lock` equal to 0 makes the matching bit of `rd_data` read 1 from the next bus clock edge. Bit 0 belongs to subcounter 0 and bit 1 to subcounter 1. Bits 31:2 of `rd_data` always read 0.
- R3: Writing 0 to a request bit has no effect. Writing 1 to a bit that already reads 1 is absorbed, so only one service results.
- R4: While `lock` is nonzero, every write is discarded. No request bit is set and no count changes because of the write.
- R5: For an enabled subcounter, the count is 0 right after the third rising `lf_clk` edge that follows the bus edge capturing the write.
- R6: A request bit keeps reading 1 until the service has been applied. It reads 0 again within three bus clock edges after the applying `lf_clk` edge.
- R7: A service to a disabled subcounter leaves its count unchanged, including a preloaded value, and raises no `lower_act`. Its request bit still clears.
- R8: When an enabled subcounter is serviced while its count is below its limit, its `lower_act` bit is high for exactly one `lf_clk` cycle after the applying edge. Otherwise the bit stays low.
- R9: When both bits are set in one write, both subcounters are serviced on the same `lf_clk` edge.
- R10: On each `lf_clk` edge an enabled subcounter counts up by one, and a disabled one holds its value. A high `pre_load` bit loads the matching preload value; this load takes priority over counting, and an applied service takes priority over the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Write strobe for the service register |
| wr_data | input | 32 | Write data; bit 0 requests subcounter 0, bit 1 requests subcounter 1 |
| lock | input | 2 | Watchdog lock field; a nonzero value discards writes |
| rd_data | output | 32 | Register readback; bits 1:0 are the pending requests |
| lf_clk | input | 1 | Slow low-frequency clock |
| sub_en | input | 2 | Subcounter enables (slow domain) |
| pre_load | input | 2 | Preload strobes (slow domain) |
| pre_val0 | input | CW | Preload value for subcounter 0 |
| pre_val1 | input | CW | Preload value for subcounter 1 |
| lim0 | input | CW | Lower limit of subcounter 0 |
| lim1 | input | CW | Lower limit of subcounter 1 |
| cnt0 | output | CW | Count of subcounter 0 |
| cnt1 | output | CW | Count of subcounter 1 |
| lower_act | output | 2 | One-cycle lower-limit action flags (slow domain) |

## Verification
The bench aims at the exact slow edge on which a clear lands. A design with one synchronizer stage too many clears a cycle late, and one that skips synchronization clears too early; both show a wrong count in the sampled cycle. A second write to a bit that is still pending is checked for a second clear several cycles later, which is what a design that queues requests would produce. Services to disabled or preloaded subcounters, and writes under lock, are checked for any change of count, request bit or `lower_act`. A `lower_act` that is held high too long, or raised with the limit test reversed, shows up at the sample taken one cycle after the applying edge.

// File: rtl/wdt_svc_sync.sv
module wdt_svc_sync #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [31:0]   wr_data,
  input  logic [1:0]    lock,
  output logic [31:0]   rd_data,
  input  logic          lf_clk,
  input  logic [1:0]    sub_en,
  input  logic [1:0]    pre_load,
  input  logic [CW-1:0] pre_val0,
  input  logic [CW-1:0] pre_val1,
  input  logic [CW-1:0] lim0,
  input  logic [CW-1:0] lim1,
  output logic [CW-1:0] cnt0,
  output logic [CW-1:0] cnt1,
  output logic [1:0]    lower_act
);

  // bus domain: request toggles and returned acknowledge
  logic [1:0] req_t, ack_b1, ack_b2;
  wire  [1:0] pend = req_t ^ ack_b2;
  wire  [1:0] set  = (wr_en && lock == 2'b00) ? (wr_data[1:0] & ~pend) : 2'b00;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      req_t  <= '0;
      ack_b1 <= '0;
      ack_b2 <= '0;
    end else begin
      req_t  <= req_t ^ set;
      ack_b1 <= ack_t;
      ack_b2 <= ack_b1;
    end

  assign rd_data = {30'b0, pend};

  a_r4_no_set_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || lock != 2'b00) |=> ((rd_data[1:0] & ~$past(rd_data[1:0])) == 2'b00));

  // slow domain: request synchronizer and acknowledge toggle
  logic [1:0] req_s1, req_s2, ack_t;
  wire  [1:0] svc = req_s2 ^ ack_t;

  always_ff @(posedge lf_clk or negedge rst_n)
    if (!rst_n) begin
      req_s1 <= '0;
      req_s2 <= '0;
      ack_t  <= '0;
    end else begin
      req_s1 <= req_t;
      req_s2 <= req_s1;
      ack_t  <= req_s2;
    end

  for (genvar i = 0; i < 2; i++) begin : g_sub
    wire [CW-1:0] pv  = (i == 0) ? pre_val0 : pre_val1;
    wire [CW-1:0] lim = (i == 0) ? lim0 : lim1;
    wire          hit = svc[i] && sub_en[i];
    logic [CW-1:0] c;
    logic          act;

    always_ff @(posedge lf_clk or negedge rst_n)
      if (!rst_n) begin
        c   <= '0;
        act <= 1'b0;
      end else begin
        act <= hit && (c < lim);
        if (hit)              c <= '0;
        else if (pre_load[i]) c <= pv;
        else if (sub_en[i])   c <= c + 1'b1;
      end

    assign lower_act[i] = act;

    a_r8_act_one_cycle: assert property (@(posedge lf_clk) disable iff (!rst_n)
      act |=> !act);
    a_r7_act_needs_enable: assert property (@(posedge lf_clk) disable iff (!rst_n)
      act |-> $past(sub_en[i]));
    a_r5_act_with_zero: assert property (@(posedge lf_clk) disable iff (!rst_n)
      act |-> (c == '0));
  end

  assign cnt0 = g_sub[0].c;
  assign cnt1 = g_sub[1].c;

endmodule

// File: tb/test_wdt_svc_sync.sv
`timescale 1ns/100ps
module test_wdt_svc_sync;
  localparam int CW = 16;

  logic clk = 0, lf_clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [31:0] wr_data = 0;
  logic [1:0] lock = 0, sub_en = 0, pre_load = 0;
  logic [CW-1:0] pre_val0 = 0, pre_val1 = 0, lim0 = 0, lim1 = 0;
  logic [31:0] rd_data;
  logic [CW-1:0] cnt0, cnt1;
  logic [1:0] lower_act;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;
  always #36.3 lf_clk = ~lf_clk;

  wdt_svc_sync #(.CW(CW)) i_wdt_svc_sync (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .lock(lock),
    .rd_data(rd_data), .lf_clk(lf_clk), .sub_en(sub_en), .pre_load(pre_load),
    .pre_val0(pre_val0), .pre_val1(pre_val1), .lim0(lim0), .lim1(lim1),
    .cnt0(cnt0), .cnt1(cnt1), .lower_act(lower_act));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply_write(logic [31:0] d, logic [1:0] lk);
    @(negedge clk);
    wr_en = 1; wr_data = d; lock = lk;
    @(posedge clk);
    wr_en <= 0; wr_data <= 0;
  endtask

  function automatic logic [CW-1:0] f_cnt(bit req, bit en, logic [CW-1:0] pre);
    if (req && en) return '0;
    if (en) return pre + 1'b1;
    return pre;
  endfunction

  function automatic bit f_act(bit req, bit en, logic [CW-1:0] pre, logic [CW-1:0] lim);
    return req && en && (pre < lim);
  endfunction

  function automatic string f_tag(bit req, bit en, bit locked, bit both);
    if (locked) return "R4 locked write";
    if (!req) return "R3 zero write";
    if (!en) return "R7 disabled service";
    return both ? "R9 joint service" : "R5 service clear";
  endfunction

  initial begin
    #(10 * 150000);
    checks++; failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [CW-1:0] p0, p1;
    void'($urandom(32'd4242));
    #203 rst_n = 1;
    #1;
    chk("R1 reset rd_data", rd_data, 0);
    chk("R1 reset cnt0", cnt0, 0);
    chk("R1 reset cnt1", cnt1, 0);
    chk("R1 reset lower_act", lower_act, 0);

    // R10 counting, hold and preload
    @(negedge lf_clk); sub_en = 2'b01;
    repeat (5) @(posedge lf_clk);
    #1 chk("R10 count up", cnt0, 5);
    chk("R10 disabled hold", cnt1, 0);
    @(negedge lf_clk); pre_val0 = 100; pre_load = 2'b01;
    @(posedge lf_clk); #1 chk("R10 preload", cnt0, 100);
    @(negedge lf_clk); pre_load = 0;
    @(posedge lf_clk); #1 chk("R10 count after preload", cnt0, 101);

    // R7 disabled preloaded subcounter
    @(negedge lf_clk); pre_val1 = 300; pre_load = 2'b10; lim1 = 16'hffff;
    @(negedge lf_clk); pre_load = 0;
    apply_write(32'h2, 2'b00);
    #1 chk("R2 bit1 pending", rd_data, 32'h2);
    repeat (3) @(posedge lf_clk);
    #1 chk("R7 preload kept", cnt1, 300);
    chk("R7 no lower action", lower_act, 0);
    repeat (3) @(posedge clk);
    #1 chk("R7 pending cleared", rd_data, 0);

    // R3 zero write and absorbed repeat write
    apply_write(32'h0, 2'b00);
    #1 chk("R3 zero write no pend", rd_data, 0);
    @(negedge lf_clk); lim0 = 0;
    apply_write(32'h1, 2'b00);
    @(posedge lf_clk);
    #1 chk("R6 still pending", rd_data, 32'h1);
    apply_write(32'h1, 2'b00);
    @(posedge lf_clk); @(posedge lf_clk);
    #1 chk("R5 cleared", cnt0, 0);
    chk("R8 no act at limit 0", lower_act, 0);
    repeat (8) @(posedge lf_clk);
    #1 chk("R3 repeat absorbed count", cnt0, 8);
    chk("R3 repeat absorbed pend", rd_data, 0);

    // R4 directed lock
    apply_write(32'h3, 2'b10);
    #1 chk("R4 locked no pend", rd_data, 0);

    // randomized service rounds
    for (int it = 0; it < 60; it++) begin
      logic [1:0] en, lk, req;
      logic [31:0] d;
      en = 2'($urandom);
      @(negedge lf_clk);
      sub_en = en;
      lim0 = 16'($urandom % 48);
      lim1 = 16'($urandom % 48);
      if ($urandom % 3 == 0) begin
        pre_val0 = 16'($urandom % 200);
        pre_val1 = 16'($urandom % 200);
        pre_load = 2'($urandom);
        @(negedge lf_clk);
        pre_load = 0;
      end
      lk = ($urandom % 3 == 0) ? 2'($urandom % 3 + 1) : 2'b00;
      d = $urandom;
      if (it % 8 == 0) d[1:0] = 2'b11;
      req = (lk == 0) ? d[1:0] : 2'b00;
      apply_write(d, lk);
      @(posedge lf_clk); @(posedge lf_clk);
      #1 p0 = cnt0; p1 = cnt1;
      chk((lk != 0) ? "R4 pend under lock" : "R2 pend readback", rd_data, {30'b0, req});
      @(posedge lf_clk);
      #1 chk(f_tag(req[0], en[0], lk != 0, req == 2'b11 && en == 2'b11), cnt0, f_cnt(req[0], en[0], p0));
      chk(f_tag(req[1], en[1], lk != 0, req == 2'b11 && en == 2'b11), cnt1, f_cnt(req[1], en[1], p1));
      chk("R8 lower action", lower_act, {f_act(req[1], en[1], p1, lim1), f_act(req[0], en[0], p0, lim0)});
      @(posedge lf_clk);
      #1 chk("R8 one cycle", lower_act, 0);
      repeat (3) @(posedge clk);
      #1 chk("R6 pend cleared", rd_data, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule